// File: doc/BRIEF.md
# Zero-Page Pointer Snooping Data Access Unit

This unit sits beside the cartridge's code-bank logic. It watches every CPU bus cycle, so any code can reach all 32 KB of ROM and all 32 KB of RAM as data without switching code banks. An indirect instruction, `(zp),y` or `(zp,x)`, makes the CPU read a pointer from zero page. When that read fetches the high byte from one of five reserved odd addresses, the unit takes two things from it. The address chooses an operation: RAM store, RAM read, RAM read-modify-write, ROM read, or ROM-to-RAM copy. Bits 7..5 of the fetched byte choose one of eight 4 KB banks.

The captured operation waits until the next cartridge-space cycle, which is any cycle with address bit 12 set. During that cycle the unit drives the ROM and RAM chip enables, the RAM write strobe and the three upper memory address bits. It also raises a steering flag, which tells the code-bank logic to stand aside. A read-modify-write keeps the steering for two cartridge cycles. Every other operation is used up by one cartridge cycle. In copy mode ROM and RAM are enabled together. The RAM then takes, at the same in-bank offset, the byte that the ROM drives onto the bus.

Top module: `zp_ptr_data_unit`

## Requirements
- R1: After reset, and whenever no operation is armed, a cartridge cycle leaves steer_active, rom_ce, ram_ce, ram_we low and mem_hi at 0.
- R2: A CPU read (cpu_rw=1) of $00FB arms a RAM store. On the next cartridge cycle ram_ce is 1, rom_ce is 0, and ram_we is 1 exactly when the CPU writes (cpu_rw=0).
- R3: A CPU read of $00F9 arms a RAM read. On the next cartridge cycle ram_ce=1, rom_ce=0, ram_we=0.
- R4: A CPU read of $00F7 arms a RAM read-modify-write. The next two cartridge cycles both go to RAM (ram_ce=1, rom_ce=0), with ram_we=1 on the cycles where cpu_rw=0. The third cartridge cycle is not steered.
- R5: A CPU read of $00F5 arms a ROM read. On the next cartridge cycle rom_ce=1, ram_ce=0, ram_we=0.
- R6: A CPU read of $00F3 arms a copy. On the next cartridge cycle rom_ce, ram_ce and ram_we are all 1.
- R7: While steering, mem_hi equals bits 7..5 of the byte read with the arming fetch, whatever the cartridge address bits 14..12 are.
- R8: A CPU write to $00F3..$00FB arms nothing, and so does any access through a mirror such as $04F3 (address bits 15..8 non-zero).
- R9: An armed operation survives cycles outside cartridge space. It is cleared after it has served its cartridge cycle(s), so a following cartridge cycle is not steered.
- R10: Reads of the even pointer-low addresses ($00F2..$00FA) arm nothing.
- R11: A new arming fetch replaces any operation that is still pending, including its bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one rising edge per CPU cycle |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address of the current cycle |
| cpu_data | input | 8 | Data bus value of the current cycle |
| cpu_rw | input | 1 | 1 = CPU read, 0 = CPU write |
| steer_active | output | 1 | This unit owns the memory enables this cycle |
| rom_ce | output | 1 | ROM chip enable |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write strobe |
| mem_hi | output | 3 | Upper memory address bits (bank) |

## Verification
The arming fetch is registered on the rising edge that ends its cycle. The steering outputs depend combinationally on the address of the current cycle. A result is therefore due in the first cartridge cycle after the fetch, and within that same cycle, whatever number of non-cartridge cycles lie between. The bench changes inputs just after a rising edge and samples outputs at the following falling edge. Its reference model advances its armed state only at the modelled rising edge, so each comparison matches the cycle in which the design's registers have already taken the fetch.

// File: rtl/zp_ptr_pkg.sv
package zp_ptr_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int BANK_W   = 3;
    localparam int BANK_LSB = DATA_W - BANK_W;
    localparam int CART_BIT = 12;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RAM_WR  = 3'd1,
        OP_RAM_RD  = 3'd2,
        OP_RAM_RMW = 3'd3,
        OP_ROM_RD  = 3'd4,
        OP_COPY    = 3'd5
    } ptr_op_e;

    typedef struct packed {
        ptr_op_e            op;
        logic [BANK_W-1:0]  bank;
        logic [1:0]         left;
    } arm_state_t;

    function automatic ptr_op_e op_from_low(input logic [7:0] lo);
        case (lo)
            8'hFB:   return OP_RAM_WR;
            8'hF9:   return OP_RAM_RD;
            8'hF7:   return OP_RAM_RMW;
            8'hF5:   return OP_ROM_RD;
            8'hF3:   return OP_COPY;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic logic op_uses_ram(input ptr_op_e op);
        return (op == OP_RAM_WR) || (op == OP_RAM_RD) ||
               (op == OP_RAM_RMW) || (op == OP_COPY);
    endfunction

endpackage

// File: rtl/zp_ptr_decode.sv
module zp_ptr_decode
    import zp_ptr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              rw,
    output logic              cap_valid,
    output ptr_op_e           cap_op,
    output logic [BANK_W-1:0] cap_bank,
    output logic              cart
);
    logic    zero_page;
    ptr_op_e lo_op;
    logic    unused_data_low;

    assign zero_page       = (addr[ADDR_W-1:8] == '0);
    assign lo_op           = op_from_low(addr[7:0]);
    assign cap_valid       = zero_page && rw && (lo_op != OP_NONE);
    assign cap_op          = cap_valid ? lo_op : OP_NONE;
    assign cap_bank        = data[DATA_W-1:BANK_LSB];
    assign cart            = addr[CART_BIT];
    assign unused_data_low = ^data[BANK_LSB-1:0];

    always_comb begin
        if (cap_valid) assert (!cart) else $error("assert_capture_not_cart_R8");
    end
endmodule

// File: rtl/zp_ptr_arm.sv
module zp_ptr_arm
    import zp_ptr_pkg::*;
#(
    parameter int RMW_SPAN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_valid,
    input  ptr_op_e           cap_op,
    input  logic [BANK_W-1:0] cap_bank,
    input  logic              cart,
    output arm_state_t        st
);
    localparam logic [1:0] SPAN_RMW = 2'(RMW_SPAN);
    localparam logic [1:0] SPAN_ONE = 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.op   <= OP_NONE;
            st.bank <= '0;
            st.left <= '0;
        end else if (cap_valid) begin
            st.op   <= cap_op;
            st.bank <= cap_bank;
            st.left <= (cap_op == OP_RAM_RMW) ? SPAN_RMW : SPAN_ONE;
        end else if (cart && st.op != OP_NONE) begin
            if (st.left <= SPAN_ONE) begin
                st.op   <= OP_NONE;
                st.left <= '0;
            end else begin
                st.left <= st.left - 2'd1;
            end
        end
    end

    assert_single_use_R9: assert property (@(posedge clk) disable iff (rst)
        (st.op != OP_NONE && st.op != OP_RAM_RMW && cart && !cap_valid) |=> (st.op == OP_NONE));

    assert_no_spurious_arm_R8: assert property (@(posedge clk) disable iff (rst)
        (st.op == OP_NONE && !cap_valid) |=> (st.op == OP_NONE));

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st.op != OP_NONE && !cap_valid) |=> $stable(st.bank));

    assert_rmw_span_R4: assert property (@(posedge clk) disable iff (rst)
        (st.left <= SPAN_RMW));
endmodule

// File: rtl/zp_ptr_steer.sv
module zp_ptr_steer
    import zp_ptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  arm_state_t        st,
    input  logic              cart,
    input  logic              rw,
    output logic              active,
    output logic              rom_ce,
    output logic              ram_ce,
    output logic              ram_we,
    output logic [BANK_W-1:0] mem_hi
);
    logic wr_kind;

    assign active  = cart && (st.op != OP_NONE);
    assign wr_kind = (st.op == OP_RAM_WR) || (st.op == OP_RAM_RMW);
    assign rom_ce  = active && ((st.op == OP_ROM_RD) || (st.op == OP_COPY));
    assign ram_ce  = active && op_uses_ram(st.op);
    assign ram_we  = active && ((st.op == OP_COPY) || (wr_kind && !rw));
    assign mem_hi  = active ? st.bank : '0;

    assert_we_needs_ce_R2: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ram_ce);

    assert_both_chips_copy_R6: assert property (@(posedge clk) disable iff (rst)
        (rom_ce && ram_ce) |-> ram_we);

    assert_rom_read_only_R5: assert property (@(posedge clk) disable iff (rst)
        (rom_ce && !ram_ce) |-> !ram_we);

    assert_enables_need_steer_R1: assert property (@(posedge clk) disable iff (rst)
        (rom_ce || ram_ce) |-> active);
endmodule

// File: rtl/zp_ptr_data_unit.sv
module zp_ptr_data_unit
    import zp_ptr_pkg::*;
#(
    parameter int RMW_SPAN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rw,
    output logic              steer_active,
    output logic              rom_ce,
    output logic              ram_ce,
    output logic              ram_we,
    output logic [2:0]        mem_hi
);
    logic              cap_valid;
    ptr_op_e           cap_op;
    logic [BANK_W-1:0] cap_bank;
    logic              cart;
    arm_state_t        st;

    zp_ptr_decode u_decode (
        .addr      (cpu_addr),
        .data      (cpu_data),
        .rw        (cpu_rw),
        .cap_valid (cap_valid),
        .cap_op    (cap_op),
        .cap_bank  (cap_bank),
        .cart      (cart)
    );

    zp_ptr_arm #(.RMW_SPAN(RMW_SPAN)) u_arm (
        .clk       (clk),
        .rst       (rst),
        .cap_valid (cap_valid),
        .cap_op    (cap_op),
        .cap_bank  (cap_bank),
        .cart      (cart),
        .st        (st)
    );

    zp_ptr_steer u_steer (
        .clk    (clk),
        .rst    (rst),
        .st     (st),
        .cart   (cart),
        .rw     (cpu_rw),
        .active (steer_active),
        .rom_ce (rom_ce),
        .ram_ce (ram_ce),
        .ram_we (ram_we),
        .mem_hi (mem_hi)
    );

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        rst |=> !steer_active);
endmodule

// File: tb/zp_ptr_data_unit_tb.sv
module zp_ptr_data_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        steer_active, rom_ce, ram_ce, ram_we;
    logic [2:0]  mem_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_op = 0;
    int m_bank = 0;
    int m_left = 0;

    always #10 clk = ~clk;

    zp_ptr_data_unit dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .steer_active(steer_active), .rom_ce(rom_ce),
        .ram_ce(ram_ce), .ram_we(ram_we), .mem_hi(mem_hi)
    );

    // op codes of the model: 0 none, 1 store, 2 read, 3 rmw, 4 rom read, 5 copy
    function automatic int op_of(input logic [15:0] a, input logic rw);
        if (a[15:8] != 8'h00 || !rw) return 0;
        case (a[7:0])
            8'hFB: return 1;
            8'hF9: return 2;
            8'hF7: return 3;
            8'hF5: return 4;
            8'hF3: return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic [6:0] expect_out(input logic [15:0] a, input logic rw);
        logic act, e_rom, e_ram, e_we;
        logic [2:0] e_hi;
        act   = a[12] && (m_op != 0);
        e_rom = act && (m_op == 4 || m_op == 5);
        e_ram = act && (m_op == 1 || m_op == 2 || m_op == 3 || m_op == 5);
        e_we  = act && (m_op == 5 || ((m_op == 1 || m_op == 3) && !rw));
        e_hi  = act ? 3'(m_bank) : 3'd0;
        return {act, e_rom, e_ram, e_we, e_hi};
    endfunction

    task automatic cyc(input logic [15:0] a, input logic rw, input logic [7:0] d,
                       input string req);
        logic [6:0] exp_v, act_v;
        int nop;
        cpu_addr = a; cpu_rw = rw; cpu_data = d;
        @(negedge clk);
        exp_v = expect_out(a, rw);
        act_v = {steer_active, rom_ce, ram_ce, ram_we, mem_hi};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s addr=%h rw=%b: actual %b expected %b", req, a, rw, act_v, exp_v);
        end
        nop = op_of(a, rw);
        if (nop != 0) begin
            m_op = nop; m_bank = int'(d[7:5]); m_left = (nop == 3) ? 2 : 1;
        end else if (a[12] && m_op != 0) begin
            if (m_left <= 1) begin m_op = 0; m_left = 0; end
            else m_left--;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cyc(16'h1000, 1'b1, 8'h00, "R1");
        cyc(16'hF800, 1'b0, 8'h00, "R1");
        // R2 store, with a non-cartridge cycle in between (R9)
        cyc(16'h00FB, 1'b1, 8'hA0, "R2");
        cyc(16'h0080, 1'b1, 8'h00, "R9");
        cyc(16'h1234, 1'b0, 8'h55, "R2");
        cyc(16'h1234, 1'b0, 8'h55, "R9");
        // R3
        cyc(16'h00F9, 1'b1, 8'h60, "R3");
        cyc(16'h3010, 1'b1, 8'h00, "R3");
        // R4 rmw: read, write, then not steered
        cyc(16'h00F7, 1'b1, 8'hE0, "R4");
        cyc(16'h5020, 1'b1, 8'h00, "R4");
        cyc(16'h5020, 1'b0, 8'h01, "R4");
        cyc(16'h5020, 1'b0, 8'h02, "R4");
        // R5
        cyc(16'h00F5, 1'b1, 8'h20, "R5");
        cyc(16'h7FFF, 1'b1, 8'h00, "R5");
        // R6
        cyc(16'h00F3, 1'b1, 8'h40, "R6");
        cyc(16'h9100, 1'b1, 8'h00, "R6");
        // R7 bank independent of address bits 14..12
        cyc(16'h00F9, 1'b1, 8'hC0, "R7");
        cyc(16'hF0FF, 1'b1, 8'h00, "R7");
        // R8 write to hotspot and mirror read arm nothing
        cyc(16'h00FB, 1'b0, 8'hE0, "R8");
        cyc(16'h1000, 1'b0, 8'h00, "R8");
        cyc(16'h04F3, 1'b1, 8'hE0, "R8");
        cyc(16'h1000, 1'b1, 8'h00, "R8");
        // R10 pointer low byte
        cyc(16'h00F4, 1'b1, 8'hE0, "R10");
        cyc(16'h1000, 1'b1, 8'h00, "R10");
        // R11 replacement
        cyc(16'h00F9, 1'b1, 8'h20, "R11");
        cyc(16'h00F5, 1'b1, 8'h80, "R11");
        cyc(16'hB000, 1'b1, 8'h00, "R11");
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [15:0] a;
            logic rw;
            k  = int'($urandom % 8);
            rw = 1'b1;
            case (k)
                0, 1, 2: a = {8'h00, 8'hF2 + 8'($urandom % 10)};
                3: begin a = {8'h00, 8'hF2 + 8'($urandom % 10)}; rw = 1'b0; end
                4: a = {8'h04, 8'hF3 + 8'(2 * ($urandom % 5))};
                default: begin
                    a = 16'($urandom) | 16'h1000;
                    rw = 1'($urandom);
                end
            endcase
            cyc(a, rw, 8'($urandom), "R9 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule